// File: doc/BRIEF.md
# Three-Wire Control Word Serialiser

This block takes 16-bit control words from a parallel host and writes them to a waveform-synthesis peripheral over a three-wire link: serial clock, serial data and an active-low frame line. Each word is split into two 8-bit bursts. The frame line stays low for the whole word, and the clock rests high between the two bursts. The peripheral latches each data bit on a falling clock edge. The block therefore changes the data line only on rising edges.

The host hands over a word with a valid/ready handshake. The word can come from a single 16-bit input. It can also be assembled from three narrower inputs: a 4-bit command nibble, a 4-bit register-select nibble and an 8-bit payload. A host that builds its bytes least-significant-bit first can set a mode input. Each byte is then mirrored before it is sent, so the most significant bit still leaves first. Three parameters set the bit rate, the pause between the two bursts and the minimum idle time between words.

Top module: `sr_word_writer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `fsync_n`=1, `sclk`=1 and `sdata`=0, and `in_ready`=1. A frame in progress is abandoned. Between frames `sdata` rests at 0.
- R2: `fsync_n` falls HALF_DIV clocks before the first falling `sclk` edge of a word. It stays low across exactly 16 falling edges and rises 2*HALF_DIV clocks after the 16th. `sclk` never falls while `fsync_n` is high.
- R3: The 16 bits sampled on the falling edges, in order, equal the transmitted word from bit 15 down to bit 0.
- R4: `sclk` is high whenever `fsync_n` is high, and it is high throughout the pause between the 8th and 9th falling edges.
- R5: During a frame, `sdata` changes only in the clock where `sclk` rises. It holds the same value in the samples just before and just after each falling edge.
- R6: Falling edges within a burst are 2*HALF_DIV clocks apart. The 8th and 9th falling edges are (2+2*GAP_BITS)*HALF_DIV clocks apart.
- R7: `in_ready` is low from the cycle after a word is accepted until 2*REST_BITS*HALF_DIV clocks after `fsync_n` rises. At that point it returns high.
- R8: With `field_sel`=1, the word is {`in_ctrl`, `in_addr`, `in_data`}: the command nibble in bits 15:12, the register-select nibble in bits 11:8 and the payload in bits 7:0. With `field_sel`=0 the word is `in_word`.
- R9: With `lsb_first`=1, bits 15:8 and bits 7:0 are each mirrored (bit k of a byte goes to bit 7-k of that byte) before transmission. Byte order is unchanged.
- R10: Changes to `in_valid`, `in_word`, the field inputs, `field_sel` and `lsb_first` after a word is accepted do not alter that word's transmitted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 16 | Whole word when field_sel is 0 |
| field_sel | input | 1 | 1: build word from the three field inputs |
| in_ctrl | input | 4 | Command nibble (word bits 15:12) |
| in_addr | input | 4 | Register-select nibble (word bits 11:8) |
| in_data | input | 8 | Payload byte (word bits 7:0) |
| lsb_first | input | 1 | 1: mirror each byte before sending |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, valid at falling sclk |
| fsync_n | output | 1 | Frame line, active low |

## Verification
The hardest situation to reach from the ports is a reset that lands mid-word, with the frame line low and the clock partway through a burst. The bench starts a word, waits about thirty clocks so that it is inside the first burst, and then pulls reset. It checks that the link returns to idle at once and that the next word goes out whole. The other case that needs deliberate stimulus is a host that keeps valid high and changes every input while a word is being sent. The bench scrambles all host inputs during such frames and compares the bits captured on the line against the word it first presented.

// File: rtl/sr_pkg.sv
// Package: shared widths and the state encoding of the word serialiser.
// Assumes a 16-bit word made of two 8-bit bursts.
package sr_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 2;
    localparam int WORD_W    = BYTE_W * NUM_BYTES;
    localparam int CTRL_W    = 4;
    localparam int ADDR_W    = 4;
    localparam int BIT_IDX_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        ST_IDLE,  // frame high, waiting for a word
        ST_LEAD,  // frame low, clock high, first bit on the line
        ST_LOW,   // clock low half of a bit
        ST_HIGH,  // clock high half of a bit within a burst
        ST_GAP,   // clock high pause between the two bursts
        ST_TAIL,  // clock high after the last bit, frame still low
        ST_REST   // frame high, minimum spacing before next word
    } wr_state_t;
endpackage

// File: rtl/sr_half_tick.sv
// Half-bit timer: asserts tick for one clock every HALF_DIV clocks.
// Assumes: clear restarts the period so the first tick comes HALF_DIV clocks later.
module sr_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick fires in the last clock of each half period.
    assign tick = (cnt_q == LAST);

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sr_word_prep.sv
// Word assembly: picks the whole-word input or the three fields, then
// optionally mirrors each byte for hosts that build bytes LSB first.
// Assumes the command nibble is topmost, then register select, then payload.
module sr_word_prep
    import sr_pkg::*;
(
    input  logic [WORD_W-1:0] raw_word,
    input  logic              field_sel,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    input  logic              lsb_first,
    output logic [WORD_W-1:0] tx_word
);
    logic [WORD_W-1:0] picked;
    logic [WORD_W-1:0] mirrored;

    // Select the word source.
    always_comb begin
        picked = field_sel ? {ctrl, addr, data} : raw_word;
    end

    // Mirror bits inside every byte; byte order is kept.
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
            assign mirrored[b*BYTE_W + k] = picked[b*BYTE_W + (BYTE_W-1-k)];
        end
    end

    // Final word as it leaves MSB first.
    always_comb begin
        tx_word = lsb_first ? mirrored : picked;
    end
endmodule

// File: rtl/sr_word_writer.sv
// Three-wire control word serialiser. One 16-bit word goes out as two
// 8-bit bursts under one low frame; the clock rests high between bursts
// and between words; data changes on rising clock, is sampled on falling.
// Assumes HALF_DIV >= 1, GAP_BITS >= 0, REST_BITS >= 1.
module sr_word_writer
    import sr_pkg::*;
#(
    parameter int HALF_DIV  = 4,  // system clocks per half bit
    parameter int GAP_BITS  = 1,  // extra bit periods between bursts
    parameter int REST_BITS = 1   // bit periods of frame-high spacing
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                field_sel,
    input  logic [CTRL_W-1:0]   in_ctrl,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [BYTE_W-1:0]   in_data,
    input  logic                lsb_first,
    output logic                sclk,
    output logic                sdata,
    output logic                fsync_n
);
    localparam int GAP_HALVES  = 1 + 2 * GAP_BITS;
    localparam int REST_HALVES = 2 * REST_BITS;
    localparam int MAX_HALVES  = (GAP_HALVES > REST_HALVES) ? GAP_HALVES : REST_HALVES;
    localparam int HCNT_W      = $clog2(MAX_HALVES + 1);
    localparam logic [HCNT_W-1:0]    GAP_LAST   = HCNT_W'(GAP_HALVES - 1);
    localparam logic [HCNT_W-1:0]    REST_LAST  = HCNT_W'(REST_HALVES - 1);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT   = BIT_IDX_W'(WORD_W - 1);
    localparam logic [BIT_IDX_W-1:0] BURST_LAST = BIT_IDX_W'(BYTE_W - 1);

    wr_state_t             state_q;
    logic [WORD_W-1:0]     shreg_q;
    logic [BIT_IDX_W-1:0]  bit_q;
    logic [HCNT_W-1:0]     hcnt_q;
    logic                  frame_q;   // internal frame, active high
    logic                  sclk_q;
    logic                  sdata_q;
    logic                  accept;
    logic                  tick;
    logic [WORD_W-1:0]     tx_word;

    // Host handshake: ready only in idle.
    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_ready && in_valid;

    // Line drivers; internal frame is inverted to the active-low pin.
    assign fsync_n = ~frame_q;
    assign sclk    = sclk_q;
    assign sdata   = sdata_q;

    sr_word_prep u_prep (
        .raw_word  (in_word),
        .field_sel (field_sel),
        .ctrl      (in_ctrl),
        .addr      (in_addr),
        .data      (in_data),
        .lsb_first (lsb_first),
        .tx_word   (tx_word)
    );

    sr_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick)
    );

    // Frame sequencer: drives clock, data and frame per half-bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            bit_q   <= '0;
            hcnt_q  <= '0;
            frame_q <= 1'b0;
            sclk_q  <= 1'b1;
            sdata_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        frame_q <= 1'b1;
                        sdata_q <= tx_word[WORD_W-1];
                        shreg_q <= {tx_word[WORD_W-2:0], 1'b0};
                        bit_q   <= '0;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk_q  <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        if (bit_q == LAST_BIT) begin
                            state_q <= ST_TAIL;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            sdata_q <= shreg_q[WORD_W-1];
                            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                            if (bit_q == BURST_LAST) begin
                                hcnt_q  <= '0;
                                state_q <= ST_GAP;
                            end else begin
                                state_q <= ST_HIGH;
                            end
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q  <= 1'b0;
                        state_q <= ST_LOW;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (hcnt_q == GAP_LAST) begin
                            sclk_q  <= 1'b0;
                            state_q <= ST_LOW;
                        end else begin
                            hcnt_q <= hcnt_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        frame_q <= 1'b0;
                        sdata_q <= 1'b0;
                        hcnt_q  <= '0;
                        state_q <= ST_REST;
                    end
                end
                ST_REST: begin
                    if (tick) begin
                        if (hcnt_q == REST_LAST) begin
                            state_q <= ST_IDLE;
                        end else begin
                            hcnt_q <= hcnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Guards on the line protocol.
    AST_CLK_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_n |-> sclk); // R4
    AST_NO_FALL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !fsync_n); // R2
    AST_DATA_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_n |-> !sdata); // R1
    AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_n && !$past(fsync_n) && (sdata != $past(sdata))) |-> $rose(sclk)); // R5
    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync_n |-> !in_ready); // R7
    AST_REST_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_n) |=> !in_ready); // R7
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (!fsync_n && sclk && !in_ready)); // R2
endmodule

// File: tb/sr_word_writer_test.sv
`timescale 1ns/1ps
module sr_word_writer_test;
    localparam int HALF = 2;
    localparam int GAPB = 1;
    localparam int RESTB = 1;
    localparam int MAXF = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [15:0] in_word = '0;
    logic field_sel = 1'b0;
    logic [3:0] in_ctrl = '0;
    logic [3:0] in_addr = '0;
    logic [7:0] in_data = '0;
    logic lsb_first = 1'b0;
    logic sclk, sdata, fsync_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_word [0:MAXF-1];
    string       exp_req  [0:MAXF-1];
    int n_sent = 0;
    int n_seen = 0;

    always #2.5 clk = ~clk;

    sr_word_writer #(.HALF_DIV(HALF), .GAP_BITS(GAPB), .REST_BITS(RESTB)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .field_sel(field_sel), .in_ctrl(in_ctrl),
        .in_addr(in_addr), .in_data(in_data), .lsb_first(lsb_first),
        .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mirror8(input logic [7:0] v);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = v[7-k];
        return r;
    endfunction

    // Line monitor: samples on the falling system clock edge.
    int cyc = 0;
    logic p_fs = 1'b1, p_sc = 1'b1, p_sd = 1'b0, p_rdy = 1'b1;
    int t_start, t_fall, t_end = -1;
    int nfall;
    logic [15:0] cap;
    bit after_fall = 1'b0;
    bit rdy_bad;
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            after_fall = 1'b0;
            t_end = -1;
        end else begin
            if (after_fall) begin
                check(sdata == p_sd, "R5", "data moved right after falling edge", sdata, p_sd);
                after_fall = 1'b0;
            end
            if (fsync_n && !sclk)
                check(1'b0, "R4", "clock low while frame high", sclk, 1);
            if (p_fs && !fsync_n) begin
                t_start = cyc; nfall = 0; cap = '0; rdy_bad = 1'b0;
            end
            if (!fsync_n) begin
                if (in_ready) rdy_bad = 1'b1;
                if (p_sc && !sclk) begin
                    nfall++;
                    cap = {cap[14:0], sdata};
                    check(sdata == p_sd, "R5", "data moved just before falling edge", sdata, p_sd);
                    after_fall = 1'b1;
                    if (nfall == 1)
                        check(cyc - t_start == HALF, "R2", "frame lead time", cyc - t_start, HALF);
                    else if (nfall == 9)
                        check(cyc - t_fall == (2 + 2*GAPB)*HALF, "R6", "burst gap",
                              cyc - t_fall, (2 + 2*GAPB)*HALF);
                    else
                        check(cyc - t_fall == 2*HALF, "R6", "bit spacing", cyc - t_fall, 2*HALF);
                    t_fall = cyc;
                end
            end
            if (!p_fs && fsync_n) begin
                check(nfall == 16, "R2", "falling edges per frame", nfall, 16);
                check(cyc - t_fall == 2*HALF, "R2", "frame tail", cyc - t_fall, 2*HALF);
                check(!rdy_bad, "R7", "ready high inside frame", rdy_bad, 0);
                check(!sdata, "R1", "data rest level", sdata, 0);
                if (n_seen < n_sent)
                    check(cap == exp_word[n_seen], exp_req[n_seen], "word on the line",
                          cap, exp_word[n_seen]);
                else
                    check(1'b0, "R2", "unexpected frame", n_seen, n_sent);
                n_seen++;
                t_end = cyc;
            end
            if (!p_rdy && in_ready && t_end >= 0) begin
                check(cyc - t_end == 2*RESTB*HALF, "R7", "ready return delay",
                      cyc - t_end, 2*RESTB*HALF);
                t_end = -1;
            end
        end
        p_fs = fsync_n; p_sc = sclk; p_sd = sdata; p_rdy = in_ready;
    end

    // Present one word; optionally scramble all host inputs during the frame.
    task automatic send(input logic [15:0] w, input bit fs, input logic [3:0] c,
                        input logic [3:0] a, input logic [7:0] d, input bit lsb,
                        input bit scramble, input string req);
        logic [15:0] raw;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_word = w; field_sel = fs; in_ctrl = c; in_addr = a; in_data = d;
        lsb_first = lsb; in_valid = 1'b1;
        raw = fs ? {c, a, d} : w;
        exp_word[n_sent] = lsb ? {mirror8(raw[15:8]), mirror8(raw[7:0])} : raw;
        exp_req[n_sent] = req;
        n_sent++;
        @(negedge clk);
        if (scramble) begin
            for (int k = 0; k < 20; k++) begin
                in_word = ~w ^ 16'(k); field_sel = ~fs; in_ctrl = ~c;
                in_addr = ~a; in_data = ~d ^ 8'(k); lsb_first = ~lsb;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check(fsync_n == 1'b1, "R1", "fsync_n in reset", fsync_n, 1);
        check(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
        check(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
        check(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: whole-word sweep, MSB first.
        for (int i = 0; i < 256; i++)
            send({8'(i), 8'(i) ^ 8'h5A}, 1'b0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 16; i++)
            send(16'h1 << i, 1'b0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, "R3");

        // R8: every command/select nibble pair through the field inputs.
        for (int c = 0; c < 16; c++)
            for (int a = 0; a < 16; a++)
                send(16'hDEAD, 1'b1, 4'(c), 4'(a), 8'(c*16 + a) ^ 8'hC3, 1'b0, 1'b0, "R8");

        // R9: per-byte mirroring, both sources.
        for (int i = 0; i < 48; i++)
            send({8'(i*7), 8'(i*13 + 1)}, 1'b0, 4'h0, 4'h0, 8'h00, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 16; i++)
            send(16'h0, 1'b1, 4'(i), 4'(15 - i), 8'(i*17), 1'b1, 1'b0, "R9");

        // R10: host inputs churn while a word is on the line.
        for (int i = 0; i < 8; i++)
            send(16'hA5C3 ^ 16'(i*16'h1111), i[0], 4'(i), 4'(i+3), 8'(i*29), i[1], 1'b1, "R10");

        // R1: reset mid-frame, then a clean word.
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_word = 16'hFFFF; field_sel = 1'b0; lsb_first = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(fsync_n == 1'b1, "R1", "fsync_n after mid-frame reset", fsync_n, 1);
        check(sclk == 1'b1, "R1", "sclk after mid-frame reset", sclk, 1);
        check(sdata == 1'b0, "R1", "sdata after mid-frame reset", sdata, 0);
        check(in_ready == 1'b1, "R1", "ready after mid-frame reset", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        send(16'h3C96, 1'b0, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0, "R1");

        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        check(n_seen == n_sent, "R2", "frames observed", n_seen, n_sent);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule